// File: doc/BRIEF.md
# Pipelined Burst Static Memory Core

This block is a clocked single-port memory that answers a burst-style control protocol. On every rising clock edge it looks at three chip selects, two burst-start strobes and a step strobe. From them it picks one action: stay deselected, open a burst at the external address, step the burst to the next word, or repeat the current word. A separate write decoder turns a global write strobe, a lane-write gate and four per-lane write enables into a lane mask. That mask decides whether the cycle reads, writes some byte lanes, or writes the whole word.

The data path is 36 bits wide, made of four 9-bit lanes, with lane 0 in bits 8:0. Read data is registered, so it appears in the cycle after the edge that sampled the address. A burst walks the two low address bits in linear order and wraps inside its aligned four-word block. Output enable and the doze input act on the output drivers at once, without waiting for a clock. Doze also blocks every operation at the clock edge. Instead of a tri-state bus, the outputs are a data word plus a drive flag, and the data word reads zero whenever the drivers are off.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle with sel_a_n high, sel_b low or sel_c_n high (and doze low) performs no access. rd_drive is 0 in the following cycle, and any open burst is closed, so later step or repeat cycles perform no access until a new start.
- R2: When selected with start_pri_n low, a burst opens at addr and the cycle is always a read, whatever all_wr_n, lane_gate_n, lane_wr_n and start_sec_n show. This strobe has priority over start_sec_n.
- R3: When selected with start_pri_n high and start_sec_n low, a burst opens at addr. The lane mask of that cycle (R6 to R8) decides read or write, and a write stores wdata of that same edge. The lane mask is kept for the rest of the burst, and rd_drive is 0 in the cycle after a write.
- R4: With both start strobes high and step_n low, an open burst moves to the next word: address bits 1:0 increment modulo 4 while bits 7:2 stay fixed. The burst keeps its read or write direction and its lane mask.
- R5: With both start strobes and step_n high, an open burst repeats the access at the current address. A read returns the same word again, and a write stores the new wdata there again.
- R6: all_wr_n low makes the lane mask all four lanes, whatever lane_gate_n and lane_wr_n show.
- R7: With all_wr_n high, the mask is empty (a read) when lane_gate_n is high, or when lane_gate_n is low and lane_wr_n is 4'b1111.
- R8: With all_wr_n high and lane_gate_n low, lane i (wdata/rd_data bits 9i+8:9i, lane 0 least significant) is written exactly when lane_wr_n[i] is 0. The other lanes keep their contents.
- R9: A read sampled at one edge shows the addressed word on rd_data, with rd_drive 1, from that edge until the next one, provided oe_n and doze are low.
- R10: oe_n high forces rd_drive to 0 and rd_data to 0 at once, without a clock edge. Lowering oe_n restores the held read word.
- R11: doze high forces rd_drive to 0 at once. At a clock edge with doze high, no access takes place and the burst state and held read word are unchanged, so both are still in effect once doze falls.
- R12: After reset, rd_drive is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Second active-low chip select |
| start_pri_n | input | 1 | Priority burst-start strobe, read only, active low |
| start_sec_n | input | 1 | Secondary burst-start strobe, direction from write decode, active low |
| step_n | input | 1 | Advance the open burst to the next word, active low |
| all_wr_n | input | 1 | Global write, writes all lanes, active low |
| lane_gate_n | input | 1 | Enables the per-lane write enables, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low, bit i for lane i |
| addr | input | 8 | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Asynchronous sleep; blocks drivers and operations |
| rd_data | output | 36 | Read data, zero while not driven |
| rd_drive | output | 1 | High while the read drivers are active |

## Verification
The hardest situation to reach is doze arriving in the middle of an open read burst while a conflicting write start is on the pins. The bench opens a read burst, raises doze and checks at once that the drivers switch off. It then presents a full-word write start at the same address with doze still high and lowers doze before the next edge. It checks that the old word is back on the drivers, and then that a repeat cycle reads that same, unmodified word at the held burst address. Wrap-around is reached by starting a write burst at an address whose low bits are 2, then reading the block back from offset 0.

// File: rtl/sbs_pkg.sv
// Package: shared types for the burst static memory core.
// Assumes: one action is chosen per clock edge; the encoding is internal only.
package sbs_pkg;

    // Action chosen by the cycle decoder for the current clock edge.
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,  // doze: nothing happens, state frozen
        ACT_DESEL   = 3'd1,  // deselected: no access, burst closed
        ACT_START_P = 3'd2,  // priority strobe: open a read burst
        ACT_START_C = 3'd3,  // secondary strobe: open burst, direction decoded
        ACT_NEXT    = 3'd4,  // step open burst to next word
        ACT_HOLD    = 3'd5   // repeat access at current word
    } act_e;

endpackage

// File: rtl/sbs_cycle_decode.sv
// Module: sbs_cycle_decode
// Purely combinational decode of the chip selects and burst strobes into one action.
// Assumes: doze has the highest priority, then deselect, then the priority start
// strobe, then the secondary start strobe, then step versus hold.
module sbs_cycle_decode
    import sbs_pkg::*;
(
    input  logic doze,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    input  logic start_pri_n,
    input  logic start_sec_n,
    input  logic step_n,
    output act_e act
);

    logic deselected;

    // Any inactive select deselects the device.
    assign deselected = sel_a_n | ~sel_b | sel_c_n;

    // Priority chain that picks the action for this edge.
    always_comb begin
        if (doze) begin
            act = ACT_IDLE;
        end else if (deselected) begin
            act = ACT_DESEL;
        end else if (!start_pri_n) begin
            act = ACT_START_P;
        end else if (!start_sec_n) begin
            act = ACT_START_C;
        end else if (!step_n) begin
            act = ACT_NEXT;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/sbs_lane_decode.sv
// Module: sbs_lane_decode
// Combinational write decoder: global write, lane gate and per-lane enables to a lane mask.
// Assumes: an all-zero mask means the cycle is a read.
module sbs_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_mask
);

    // Global write overrides; otherwise the gate enables per-lane selects.
    always_comb begin
        if (!all_wr_n) begin
            lane_mask = '1;
        end else if (lane_gate_n) begin
            lane_mask = '0;
        end else begin
            lane_mask = ~lane_wr_n;
        end
    end

endmodule

// File: rtl/sbs_burst_seq.sv
// Module: sbs_burst_seq
// Burst state: current address, open flag, direction and latched lane mask.
// Produces the access request (enable, address, write, mask) for this edge.
// Assumes: the burst counter covers BURST_W low address bits and wraps inside
// its aligned block; upper bits never change during a burst.
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2,
    parameter int LANES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [LANES-1:0]  dec_mask,
    output logic              acc_en,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask,
    output logic              active,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] cur_q;
    logic              active_q;
    logic              wr_q;
    logic [LANES-1:0]  mask_q;
    logic [ADDR_W-1:0] step_addr;
    logic [BURST_W-1:0] low_next;

    // Linear step of the low bits, wrapping inside the block.
    assign low_next  = cur_q[BURST_W-1:0] + BURST_W'(1);
    assign step_addr = {cur_q[ADDR_W-1:BURST_W], low_next};

    // Choose the access performed at this edge from the action and burst state.
    always_comb begin
        acc_en   = 1'b0;
        acc_wr   = 1'b0;
        acc_addr = cur_q;
        acc_mask = mask_q;
        case (act)
            ACT_START_P: begin
                acc_en   = 1'b1;
                acc_addr = ext_addr;
                acc_mask = '0;
            end
            ACT_START_C: begin
                acc_en   = 1'b1;
                acc_addr = ext_addr;
                acc_wr   = |dec_mask;
                acc_mask = dec_mask;
            end
            ACT_NEXT: begin
                acc_en   = active_q;
                acc_wr   = wr_q;
                acc_addr = step_addr;
            end
            ACT_HOLD: begin
                acc_en   = active_q;
                acc_wr   = wr_q;
            end
            default: begin
                acc_en   = 1'b0;
            end
        endcase
        if (!rst_n) begin
            acc_en = 1'b0;
        end
    end

    // Update burst state: open, close, remember direction and current word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            mask_q   <= '0;
        end else begin
            case (act)
                ACT_START_P: begin
                    active_q <= 1'b1;
                    wr_q     <= 1'b0;
                    mask_q   <= '0;
                end
                ACT_START_C: begin
                    active_q <= 1'b1;
                    wr_q     <= |dec_mask;
                    mask_q   <= dec_mask;
                end
                ACT_DESEL: begin
                    active_q <= 1'b0;
                end
                default: begin
                    active_q <= active_q;
                end
            endcase
            if (acc_en) begin
                cur_q <= acc_addr;
            end
        end
    end

    assign active   = active_q;
    assign cur_addr = cur_q;

endmodule

// File: rtl/sbs_lane_array.sv
// Module: sbs_lane_array
// Storage split into independent byte lanes, each with its own write enable,
// plus a registered read word and its valid flag.
// Assumes: a cycle either reads or writes; freeze holds the read register.
module sbs_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    freeze,
    input  logic                    acc_en,
    input  logic                    acc_wr,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        acc_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_word,
    output logic                    rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic rd_valid_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] lane_q;

        // Write this lane when selected; capture it on a read.
        always_ff @(posedge clk) begin
            if (acc_en && acc_wr && acc_mask[l]) begin
                store[acc_addr] <= wdata[l*LANE_W +: LANE_W];
            end
            if (acc_en && !acc_wr) begin
                lane_q <= store[acc_addr];
            end
        end

        assign rd_word[l*LANE_W +: LANE_W] = lane_q;
    end

    // Track whether the read register holds data to drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
        end else if (acc_en) begin
            rd_valid_q <= !acc_wr;
        end else if (!freeze) begin
            rd_valid_q <= 1'b0;
        end
    end

    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/sync_burst_sram.sv
// Module: sync_burst_sram (top)
// Burst static memory core: cycle decode, write decode, burst sequencer and
// lane storage, with asynchronous output enable and doze gating the drivers.
// Assumes: all control, address and data inputs meet timing at the rising edge;
// rd_data reads zero whenever rd_drive is low.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    start_pri_n,
    input  logic                    start_sec_n,
    input  logic                    step_n,
    input  logic                    all_wr_n,
    input  logic                    lane_gate_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    doze,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);

    localparam int DATA_W = LANES * LANE_W;

    act_e              cycle_act;
    logic [LANES-1:0]  dec_mask;
    logic              acc_en;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_mask;
    logic              burst_active;
    logic [ADDR_W-1:0] burst_addr;
    logic [DATA_W-1:0] rd_word;
    logic              rd_valid;

    sbs_cycle_decode u_cycle (
        .doze        (doze),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .start_pri_n (start_pri_n),
        .start_sec_n (start_sec_n),
        .step_n      (step_n),
        .act         (cycle_act)
    );

    sbs_lane_decode #(.LANES(LANES)) u_lanes (
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .lane_mask   (dec_mask)
    );

    sbs_burst_seq #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W),
        .LANES   (LANES)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (cycle_act),
        .ext_addr (addr),
        .dec_mask (dec_mask),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .acc_mask (acc_mask),
        .active   (burst_active),
        .cur_addr (burst_addr)
    );

    sbs_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (doze),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .acc_mask (acc_mask),
        .wdata    (wdata),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    // Asynchronous driver gating by output enable and doze.
    assign rd_drive = rd_valid & ~oe_n & ~doze;
    assign rd_data  = rd_drive ? rd_word : '0;

endmodule

// File: rtl/sbs_burst_checker.sv
// Module: sbs_burst_checker
// Temporal checks on the core, attached to the top by the bind below.
// Assumes: BURST_W low address bits form the burst counter.
module sbs_burst_checker
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input act_e              act,
    input logic              active,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              oe_n,
    input logic              doze,
    input logic              rd_drive
);

    AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_DESEL) |=> !rd_drive); // R1

    AST_PRI_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_START_P) |=> (rd_drive || oe_n || doze)); // R2

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NEXT && active) |=>
            (cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + BURST_W'(1)) &&
            (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))); // R4

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD) |=> $stable(cur_addr)); // R5

    AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rd_drive); // R10

    AST_DOZE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE) |=> ($stable(cur_addr) && $stable(active))); // R11

endmodule

bind sync_burst_sram sbs_burst_checker #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (cycle_act),
    .active   (burst_active),
    .cur_addr (burst_addr),
    .oe_n     (oe_n),
    .doze     (doze),
    .rd_drive (rd_drive)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_a_n, sel_b, sel_c_n;
    logic        start_pri_n, start_sec_n, step_n;
    logic        all_wr_n, lane_gate_n;
    logic [3:0]  lane_wr_n;
    logic [7:0]  addr;
    logic [35:0] wdata;
    logic        oe_n, doze;
    logic [35:0] rd_data;
    logic        rd_drive;

    int n_checks = 0;
    int n_err    = 0;
    logic [35:0] exp_mem [256];

    sync_burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .start_pri_n(start_pri_n), .start_sec_n(start_sec_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .doze(doze),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
        $finish;
    end

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Lane mask from the write controls, per R6, R7, R8.
    function automatic logic [3:0] mask_of(input logic aw_n, input logic g_n, input logic [3:0] lw_n);
        if (!aw_n) return 4'hF;
        if (g_n) return 4'h0;
        return ~lw_n;
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d, input logic [3:0] m);
        logic [35:0] r = old;
        for (int l = 0; l < 4; l++) if (m[l]) r[l*9 +: 9] = d[l*9 +: 9];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic drive(input logic sa_n, input logic sb, input logic sc_n,
                         input logic p_n, input logic s_n, input logic st_n,
                         input logic aw_n, input logic g_n, input logic [3:0] lw_n,
                         input logic [7:0] a, input logic [35:0] d);
        sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
        start_pri_n = p_n; start_sec_n = s_n; step_n = st_n;
        all_wr_n = aw_n; lane_gate_n = g_n; lane_wr_n = lw_n;
        addr = a; wdata = d;
        tick();
    endtask

    task automatic op_sec(input logic [7:0] a, input logic [35:0] d,
                          input logic aw_n, input logic g_n, input logic [3:0] lw_n);
        drive(0, 1, 0, 1, 0, 1, aw_n, g_n, lw_n, a, d);
    endtask
    task automatic op_pri(input logic [7:0] a, input logic [35:0] d, input logic aw_n, input logic sec_n);
        drive(0, 1, 0, 0, sec_n, 1, aw_n, 1, 4'hF, a, d);
    endtask
    task automatic op_next(input logic [35:0] d);
        drive(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 8'h00, d);
    endtask
    task automatic op_hold(input logic [35:0] d);
        drive(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 8'h00, d);
    endtask
    task automatic op_desel();
        drive(1, 1, 0, 1, 1, 1, 1, 1, 4'hF, 8'h00, 36'h0);
    endtask

    task automatic t_reset();
        oe_n = 0; doze = 0; rst_n = 0;
        op_desel(); op_desel(); op_desel();
        rst_n = 1;
        check("R12 drive after reset", 36'(rd_drive), 36'h0);
        op_hold(36'h0);
        check("R12 no burst open after reset", 36'(rd_drive), 36'h0);
    endtask

    task automatic t_write_burst();
        logic [35:0] d [4] = '{36'h1_2345_6789, 36'h9_8765_4321, 36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5};
        op_sec(8'h10, d[0], 0, 1, 4'hF);
        exp_mem[8'h10] = d[0];
        check("R3 write cycle floats", 36'(rd_drive), 36'h0);
        for (int i = 1; i < 4; i++) begin
            op_next(d[i]);
            exp_mem[8'h10 + i] = d[i];
            check("R4 write direction kept", 36'(rd_drive), 36'h0);
        end
        op_desel();
        op_pri(8'h10, 36'hF_FFFF_FFFF, 0, 1);
        check("R2 R9 pri start reads", rd_data, d[0]);
        check("R9 drive on read", 36'(rd_drive), 36'h1);
        for (int i = 1; i < 4; i++) begin
            op_next(36'h0);
            check("R4 read step", rd_data, d[i]);
        end
        op_next(36'h0);
        check("R4 wrap to block start", rd_data, d[0]);
        op_desel();
        op_sec(8'h10, 36'h0, 1, 1, 4'hF);
        check("R2 pri start wrote nothing", rd_data, d[0]);
        op_desel();
    endtask

    task automatic t_priority();
        op_pri(8'h11, 36'h0_0000_0000, 0, 0);
        check("R2 pri beats sec, reads", rd_data, exp_mem[8'h11]);
        check("R2 pri beats sec, drives", 36'(rd_drive), 36'h1);
        op_desel();
        op_sec(8'h11, 36'h0, 1, 1, 4'hF);
        check("R2 location intact", rd_data, exp_mem[8'h11]);
        op_desel();
    endtask

    task automatic t_read_decodes();
        op_sec(8'h11, 36'h0_0000_0000, 1, 1, 4'h0);
        check("R7 gate high reads", rd_data, exp_mem[8'h11]);
        check("R7 gate high drives", 36'(rd_drive), 36'h1);
        op_desel();
        op_sec(8'h12, 36'h0_0000_0000, 1, 0, 4'hF);
        check("R7 no lanes reads", rd_data, exp_mem[8'h12]);
        op_desel();
    endtask

    task automatic t_lanes();
        logic [35:0] w = 36'h3_3333_3333;
        logic [3:0]  m = mask_of(1, 0, 4'b0101);
        op_sec(8'h10, w, 1, 0, 4'b0101);
        exp_mem[8'h10] = merge(exp_mem[8'h10], w, m);
        op_desel();
        op_sec(8'h10, 36'h0, 1, 1, 4'hF);
        check("R8 lanes 1 and 3 written", rd_data, exp_mem[8'h10]);
        op_desel();
    endtask

    task automatic t_override();
        logic [35:0] w = 36'hC_0FFE_E123;
        op_sec(8'h13, w, 0, 1, 4'hF);
        exp_mem[8'h13] = w;
        check("R6 override write floats", 36'(rd_drive), 36'h0);
        op_desel();
        op_sec(8'h13, 36'h0, 1, 1, 4'hF);
        check("R6 global write stored all lanes", rd_data, w);
        op_desel();
    endtask

    task automatic t_wrap();
        logic [35:0] e [4] = '{36'h0_1111_0000, 36'h0_2222_0000, 36'h0_3333_0000, 36'h0_4444_0000};
        op_sec(8'h22, e[0], 0, 1, 4'hF);
        op_next(e[1]);
        op_next(e[2]);
        op_next(e[3]);
        exp_mem[8'h22] = e[0]; exp_mem[8'h23] = e[1];
        exp_mem[8'h20] = e[2]; exp_mem[8'h21] = e[3];
        op_desel();
        op_pri(8'h20, 36'h0, 1, 1);
        check("R4 wrap word 0", rd_data, e[2]);
        op_next(36'h0);
        check("R4 wrap word 1", rd_data, e[3]);
        op_next(36'h0);
        check("R4 wrap word 2", rd_data, e[0]);
        op_next(36'h0);
        check("R4 wrap word 3", rd_data, e[1]);
        op_desel();
    endtask

    task automatic t_suspend();
        op_sec(8'h30, 36'h0_AAAA_0001, 0, 1, 4'hF);
        op_hold(36'h0_AAAA_0002);
        op_next(36'h0_AAAA_0003);
        exp_mem[8'h30] = 36'h0_AAAA_0002;
        exp_mem[8'h31] = 36'h0_AAAA_0003;
        op_desel();
        op_pri(8'h30, 36'h0, 1, 1);
        check("R5 repeated write kept last", rd_data, exp_mem[8'h30]);
        op_hold(36'h0);
        check("R5 repeated read same word", rd_data, exp_mem[8'h30]);
        op_next(36'h0);
        check("R5 step after suspend", rd_data, exp_mem[8'h31]);
        op_desel();
    endtask

    task automatic t_desel();
        for (int v = 0; v < 3; v++) begin
            op_pri(8'h10, 36'h0, 1, 1);
            check("R1 read before deselect", 36'(rd_drive), 36'h1);
            drive(v == 0, v != 1, v == 2, 1, 1, 0, 1, 1, 4'hF, 8'h00, 36'h0);
            check("R1 deselect floats", 36'(rd_drive), 36'h0);
            op_next(36'h0);
            check("R1 burst closed", 36'(rd_drive), 36'h0);
        end
        op_desel();
    endtask

    task automatic t_oe();
        op_pri(8'h12, 36'h0, 1, 1);
        oe_n = 1;
        #1;
        check("R10 oe high floats", 36'(rd_drive), 36'h0);
        check("R10 data zero", rd_data, 36'h0);
        oe_n = 0;
        #1;
        check("R10 oe low restores", rd_data, exp_mem[8'h12]);
        op_desel();
    endtask

    task automatic t_sleep();
        op_pri(8'h10, 36'h0, 1, 1);
        doze = 1;
        #1;
        check("R11 doze floats at once", 36'(rd_drive), 36'h0);
        op_sec(8'h10, 36'hD_EADB_EEF0, 0, 1, 4'hF);
        doze = 0;
        #1;
        check("R11 read word held", rd_data, exp_mem[8'h10]);
        check("R11 drive back", 36'(rd_drive), 36'h1);
        op_hold(36'h0);
        check("R11 burst held, no write", rd_data, exp_mem[8'h10]);
        op_desel();
    endtask

    initial begin
        t_reset();
        t_write_burst();
        t_priority();
        t_read_decodes();
        t_lanes();
        t_override();
        t_wrap();
        t_suspend();
        t_desel();
        t_oe();
        t_sleep();
        summary();
        $finish;
    end

endmodule